// File: doc/BRIEF.md
# Direct-Access Host FIFO and Mailbox Port

This block sits between a host bus and an on-board controller. The host reaches every register through a small address window, with no indirection. Each register sits at its own offset. The host streams data to the board through an outbound FIFO and collects data from the board through an inbound FIFO. Both FIFOs pass through a data port that works either one byte or one 16-bit word at a time. Short control messages travel through a pair of 6-bit mailboxes.

The host reads a status byte to learn the fill state of both FIFOs and both mailboxes. It writes an enable byte that chooses which of those conditions raise the host interrupt. The enable byte has its own bit layout, which does not match the status layout. The board side pops the outbound FIFO, pushes the inbound FIFO, writes the inbound mailbox and reads the outbound mailbox.

A static strap input trims the usable FIFO depth. A mode input selects the width of the data path. A host write to the reset offset clears the whole port and sends a one-cycle reset pulse to the board.

Top module: `hfm_host_port`

## Requirements
- R1: A host write to offset 0 places a value at the tail of the outbound FIFO, and a host read at offset 0 removes the head of the inbound FIFO. Both FIFOs deliver values in arrival order. The board sees the outbound head on `brd_out_data`, with `brd_out_valid` high while that FIFO holds data.
- R2: With `wide_mode` high, a full 16-bit word is one FIFO entry. With it low, each byte is one entry: bits 15:8 are discarded on entry and read back as zero.
- R3: The FIFO entry capacity is 2^(AW - `depth_strap`). With the defaults this is 16 entries at strap 0 and 8 entries at strap 1, so the byte capacity in narrow mode is half of that in wide mode. A push into a full FIFO is dropped.
- R4: A host read at offset 2 returns the status byte in bits 7:0. The bits are: 0x80 outbound mailbox unread by the board, 0x40 outbound FIFO full, 0x20 inbound FIFO empty, 0x10 outbound FIFO at least half full, 0x08 inbound FIFO at least half full, 0x04 inbound mailbox full, 0x02 inbound FIFO full, 0x01 outbound FIFO empty. After reset the status is 0x21.
- R5: A "half full" flag is set when the entry count is at least half the capacity.
- R6: A host write at offset 2 loads the enable byte. The enable bits are: 0x40 inbound mailbox full, 0x20 inbound FIFO full, 0x08 inbound FIFO empty, 0x04 outbound FIFO full, 0x01 outbound FIFO empty. `host_irq` is the OR of each enable bit ANDed with its condition. Bits 0x10 and 0x02 are reserved and enable nothing.
- R7: Both mailboxes keep only bits 7:2 of the value written. Bits 1:0 always read back as zero.
- R8: A host read at offset 3 returns the inbound mailbox when enable bit 0x80 is clear, which is the reset value. With that bit set, the read returns the outbound mailbox.
- R9: A host write at offset 3 loads the outbound mailbox and sets status 0x80. A board read (`brd_mail_rd`) clears only status 0x80, and the mailbox contents stay unchanged.
- R10: A board mailbox write sets status 0x04. A host read of the inbound mailbox (offset 3 with 0x80 clear) clears status 0x04.
- R11: A host write at offset 7 empties both FIFOs, zeroes both mailboxes and their flags, and clears the enable byte. It also drives `brd_reset` high for exactly the next cycle.
- R12: A host read at offset 0 with the inbound FIFO empty returns zero and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_mode | input | 1 | 1: 16-bit data path, 0: 8-bit |
| depth_strap | input | SW | FIFO depth trim (static) |
| host_addr | input | 3 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data (same cycle) |
| host_irq | output | 1 | Host interrupt request |
| brd_reset | output | 1 | One-cycle board reset pulse |
| brd_out_pop | input | 1 | Board pops outbound FIFO |
| brd_out_data | output | DW | Outbound FIFO head |
| brd_out_valid | output | 1 | Outbound FIFO not empty |
| brd_in_push | input | 1 | Board pushes inbound FIFO |
| brd_in_data | input | DW | Inbound push data |
| brd_in_ready | output | 1 | Inbound FIFO not full |
| brd_mail_wr | input | 1 | Board writes inbound mailbox |
| brd_mail_wdata | input | 8 | Inbound mailbox write data |
| brd_mail_rd | input | 1 | Board reads outbound mailbox |
| brd_out_mail | output | 8 | Outbound mailbox contents |
| brd_out_mail_pend | output | 1 | Outbound mailbox unread |
| brd_in_mail_full | output | 1 | Inbound mailbox unread by host |

## Verification
Several properties are checked on every cycle, whatever the traffic:
- the FIFO count never passes the strapped capacity, and a push into a full FIFO leaves the count alone;
- mailbox reads never show the two low bits;
- a board read of the outbound mailbox keeps its contents while it drops the pending flag;
- a host read of the inbound mailbox clears its flag;
- narrow-mode data reads have a zero upper byte;
- the cycle after a reset write shows no interrupt and no outbound data.

Other behaviours depend on values built up over whole sequences, so only the bench scenarios can show them. These are the arrival order of FIFO data, the exact status byte at each fill level, and the mapping of each enable bit onto its own condition, including the reserved bits. The same holds for which mailbox the readback select exposes.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

  // Host register offsets
  localparam logic [2:0] ADR_DATA  = 3'd0;
  localparam logic [2:0] ADR_STAT  = 3'd2;
  localparam logic [2:0] ADR_MBOX  = 3'd3;
  localparam logic [2:0] ADR_RESET = 3'd7;

  // Enable-byte bit positions (layout differs from status)
  localparam int EN_RBSEL     = 7;
  localparam int EN_IN_MAIL   = 6;
  localparam int EN_IN_FULL   = 5;
  localparam int EN_IN_EMPTY  = 3;
  localparam int EN_OUT_FULL  = 2;
  localparam int EN_OUT_EMPTY = 0;

  // Status byte, MSB first: 0x80 down to 0x01
  typedef struct packed {
    logic out_mail_pend;
    logic out_full;
    logic in_empty;
    logic out_half;
    logic in_half;
    logic in_mail_full;
    logic in_full;
    logic out_empty;
  } hfm_status_t;

  // Mailboxes carry six bits; the two low bits are forced to zero
  function automatic logic [7:0] mbox_trim(input logic [7:0] d);
    return {d[7:2], 2'b00};
  endfunction

endpackage

// File: rtl/hfm_fifo.sv
module hfm_fifo #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [SW-1:0] strap,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic          half
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic [AW:0]   cap_w;
  logic [AW:0]   capm1;
  logic          do_push, do_pop;

  // Usable capacity from the strap
  always_comb begin
    if (int'(strap) >= AW) cap_w = (AW+1)'(1);
    else                   cap_w = (AW+1)'(1) << (AW - int'(strap));
    capm1 = cap_w - (AW+1)'(1);
  end

  assign full    = (count >= cap_w);
  assign empty   = (count == '0);
  assign half    = (count >= (cap_w >> 1));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp + 1'b1) & capm1[AW-1:0];
      if (do_pop)  rp <= (rp + 1'b1) & capm1[AW-1:0];
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap_w) else $error("fifo count above capacity"); // R3

  AST_FIFO_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)))
    else $error("push into full fifo changed count"); // R3

endmodule

// File: rtl/hfm_mbox.sv
module hfm_mbox
  import hfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  input  logic       rb_sel,
  output logic [7:0] host_rdata,
  input  logic       brd_wr,
  input  logic [7:0] brd_wdata,
  input  logic       brd_rd,
  output logic [7:0] out_mail,
  output logic       out_pend,
  output logic       in_full
);

  logic [7:0] in_mail;
  logic       host_in_read;

  assign host_in_read = host_rd && !rb_sel;
  assign host_rdata   = rb_sel ? out_mail : in_mail;

  // Outbound: host writes, board reads; contents survive the board read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mail <= '0;
      out_pend <= 1'b0;
    end else if (clr) begin
      out_mail <= '0;
      out_pend <= 1'b0;
    end else if (host_wr) begin
      out_mail <= mbox_trim(host_wdata);
      out_pend <= 1'b1;
    end else if (brd_rd) begin
      out_pend <= 1'b0;
    end
  end

  // Inbound: board writes, host reads; read drops only the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mail <= '0;
      in_full <= 1'b0;
    end else if (clr) begin
      in_mail <= '0;
      in_full <= 1'b0;
    end else if (brd_wr) begin
      in_mail <= mbox_trim(brd_wdata);
      in_full <= 1'b1;
    end else if (host_in_read) begin
      in_full <= 1'b0;
    end
  end

  AST_MB_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[1:0] == 2'b00) else $error("mailbox low bits not zero"); // R7

  AST_MB_KEEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (brd_rd && !host_wr && !clr) |=> ((out_mail == $past(out_mail)) && !out_pend))
    else $error("board read altered outbound mailbox"); // R9

  AST_MB_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_in_read && !brd_wr && !clr) |=> !in_full)
    else $error("host read left inbound mailbox full"); // R10

endmodule

// File: rtl/hfm_host_port.sv
module hfm_host_port
  import hfm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic [SW-1:0] depth_strap,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  output logic          brd_reset,
  input  logic          brd_out_pop,
  output logic [DW-1:0] brd_out_data,
  output logic          brd_out_valid,
  input  logic          brd_in_push,
  input  logic [DW-1:0] brd_in_data,
  output logic          brd_in_ready,
  input  logic          brd_mail_wr,
  input  logic [7:0]    brd_mail_wdata,
  input  logic          brd_mail_rd,
  output logic [7:0]    brd_out_mail,
  output logic          brd_out_mail_pend,
  output logic          brd_in_mail_full
);

  localparam int HB = DW / 2;

  // Narrow mode keeps the low byte only
  function automatic logic [DW-1:0] lane_trim(input logic [DW-1:0] d, input logic wide);
    return wide ? d : {{(DW-HB){1'b0}}, d[HB-1:0]};
  endfunction

  // Named decode events
  logic soft_rst, data_wr, data_rd, stat_wr, mbox_wr, mbox_rd;
  assign soft_rst = host_wr && (host_addr == ADR_RESET);
  assign data_wr  = host_wr && (host_addr == ADR_DATA);
  assign data_rd  = host_rd && (host_addr == ADR_DATA);
  assign stat_wr  = host_wr && (host_addr == ADR_STAT);
  assign mbox_wr  = host_wr && (host_addr == ADR_MBOX);
  assign mbox_rd  = host_rd && (host_addr == ADR_MBOX);

  // Enable byte, kept as its meaningful bits only
  logic       rbsel_q;
  logic [4:0] ien_q;   // {in_mail, in_full, in_empty, out_full, out_empty}

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbsel_q   <= 1'b0;
      ien_q     <= '0;
      brd_reset <= 1'b0;
    end else begin
      brd_reset <= soft_rst;
      if (soft_rst) begin
        rbsel_q <= 1'b0;
        ien_q   <= '0;
      end else if (stat_wr) begin
        rbsel_q <= host_wdata[EN_RBSEL];
        ien_q   <= {host_wdata[EN_IN_MAIL], host_wdata[EN_IN_FULL],
                    host_wdata[EN_IN_EMPTY], host_wdata[EN_OUT_FULL],
                    host_wdata[EN_OUT_EMPTY]};
      end
    end
  end

  // FIFOs
  logic          out_full, out_empty, out_half;
  logic          in_full, in_empty, in_half;
  logic [DW-1:0] in_head;

  hfm_fifo #(.DW(DW), .AW(AW), .SW(SW)) u_out_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst),
    .strap (depth_strap),
    .push  (data_wr),
    .wdata (lane_trim(host_wdata, wide_mode)),
    .pop   (brd_out_pop),
    .rdata (brd_out_data),
    .full  (out_full),
    .empty (out_empty),
    .half  (out_half)
  );

  hfm_fifo #(.DW(DW), .AW(AW), .SW(SW)) u_in_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst),
    .strap (depth_strap),
    .push  (brd_in_push),
    .wdata (lane_trim(brd_in_data, wide_mode)),
    .pop   (data_rd),
    .rdata (in_head),
    .full  (in_full),
    .empty (in_empty),
    .half  (in_half)
  );

  assign brd_out_valid = !out_empty;
  assign brd_in_ready  = !in_full;

  // Mailboxes
  logic [7:0] mbox_rdata;

  hfm_mbox u_mbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .host_wr    (mbox_wr),
    .host_rd    (mbox_rd),
    .host_wdata (host_wdata[7:0]),
    .rb_sel     (rbsel_q),
    .host_rdata (mbox_rdata),
    .brd_wr     (brd_mail_wr),
    .brd_wdata  (brd_mail_wdata),
    .brd_rd     (brd_mail_rd),
    .out_mail   (brd_out_mail),
    .out_pend   (brd_out_mail_pend),
    .in_full    (brd_in_mail_full)
  );

  // Status byte
  hfm_status_t status;
  always_comb begin
    status.out_mail_pend = brd_out_mail_pend;
    status.out_full      = out_full;
    status.in_empty      = in_empty;
    status.out_half      = out_half;
    status.in_half       = in_half;
    status.in_mail_full  = brd_in_mail_full;
    status.in_full       = in_full;
    status.out_empty     = out_empty;
  end

  // Interrupt: each enable paired with its own condition
  logic [4:0] irq_cond;
  assign irq_cond = {brd_in_mail_full, in_full, in_empty, out_full, out_empty};
  assign host_irq = |(ien_q & irq_cond);

  // Host read mux
  always_comb begin
    case (host_addr)
      ADR_DATA: host_rdata = in_empty ? '0 : lane_trim(in_head, wide_mode);
      ADR_STAT: host_rdata = {{(DW-8){1'b0}}, status};
      ADR_MBOX: host_rdata = {{(DW-8){1'b0}}, mbox_rdata};
      default:  host_rdata = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!host_irq && !brd_out_valid && brd_reset))
    else $error("reset write left activity"); // R11

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && data_rd) |-> (host_rdata[DW-1:HB] == '0))
    else $error("narrow read upper byte nonzero"); // R2

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && in_empty) |-> (host_rdata == '0))
    else $error("empty data read nonzero"); // R12

endmodule

// File: tb/hfm_host_port_bench.sv
`timescale 1ns/1ps
module hfm_host_port_bench;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_mode = 1'b1;
  logic [SW-1:0] depth_strap = '0;
  logic [2:0]    host_addr = '0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_irq, brd_reset;
  logic          brd_out_pop = 1'b0;
  logic [DW-1:0] brd_out_data;
  logic          brd_out_valid;
  logic          brd_in_push = 1'b0;
  logic [DW-1:0] brd_in_data = '0;
  logic          brd_in_ready;
  logic          brd_mail_wr = 1'b0;
  logic [7:0]    brd_mail_wdata = '0;
  logic          brd_mail_rd = 1'b0;
  logic [7:0]    brd_out_mail;
  logic          brd_out_mail_pend, brd_in_mail_full;

  always #2.5 clk = ~clk;

  hfm_host_port #(.DW(DW), .AW(AW), .SW(SW)) u_hfm_host_port (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .depth_strap(depth_strap),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .brd_reset(brd_reset), .brd_out_pop(brd_out_pop), .brd_out_data(brd_out_data),
    .brd_out_valid(brd_out_valid), .brd_in_push(brd_in_push), .brd_in_data(brd_in_data),
    .brd_in_ready(brd_in_ready), .brd_mail_wr(brd_mail_wr), .brd_mail_wdata(brd_mail_wdata),
    .brd_mail_rd(brd_mail_rd), .brd_out_mail(brd_out_mail),
    .brd_out_mail_pend(brd_out_mail_pend), .brd_in_mail_full(brd_in_mail_full)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  logic [DW-1:0] exp_out[$];
  logic [DW-1:0] exp_in[$];
  bit m_out_pend = 0, m_in_mail = 0;

  function automatic int cap_m();
    return 16 >> depth_strap;
  endfunction

  function automatic logic [DW-1:0] trim_m(input logic [DW-1:0] d);
    return wide_mode ? d : (d & 16'h00FF);
  endfunction

  function automatic logic [DW-1:0] status_m();
    logic [7:0] s;
    int c;
    c = cap_m();
    s = 8'h00;
    if (m_out_pend)              s |= 8'h80;
    if (exp_out.size() >= c)     s |= 8'h40;
    if (exp_in.size() == 0)      s |= 8'h20;
    if (exp_out.size() >= c / 2) s |= 8'h10;
    if (exp_in.size() >= c / 2)  s |= 8'h08;
    if (m_in_mail)               s |= 8'h04;
    if (exp_in.size() >= c)      s |= 8'h02;
    if (exp_out.size() == 0)     s |= 8'h01;
    return {8'h00, s};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Tasks start and end one time unit after a rising edge
  task automatic host_write(input logic [2:0] a, input logic [DW-1:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [DW-1:0] v);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    v = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic host_push(input logic [DW-1:0] d);
    if (exp_out.size() < cap_m()) exp_out.push_back(trim_m(d));
    host_write(3'd0, d);
  endtask

  task automatic host_pop(input string req);
    logic [DW-1:0] v, e;
    e = (exp_in.size() > 0) ? exp_in.pop_front() : '0;
    host_read(3'd0, v);
    check(req, v, e);
  endtask

  task automatic check_status(input string req);
    logic [DW-1:0] v, e;
    e = status_m();
    host_read(3'd2, v);
    check(req, v, e);
  endtask

  task automatic brd_pop();
    brd_out_pop = 1'b1;
    @(posedge clk); #1;
    brd_out_pop = 1'b0;
  endtask

  task automatic brd_push(input logic [DW-1:0] d);
    if (exp_in.size() < cap_m()) exp_in.push_back(trim_m(d));
    brd_in_data = d; brd_in_push = 1'b1;
    @(posedge clk); #1;
    brd_in_push = 1'b0;
  endtask

  task automatic sample_at_neg(input string req, input logic [DW-1:0] act_now, input logic [DW-1:0] exp);
    check(req, act_now, exp);
  endtask

  // Monitor: compares each board-side pop against the scoreboard
  always @(negedge clk) begin
    if (rst_n && brd_out_pop) begin
      if (exp_out.size() == 0) check("R1 unexpected pop", {15'd0, brd_out_valid}, 16'd0);
      else begin
        check("R1 valid", {15'd0, brd_out_valid}, 16'd1);
        check("R1 order", brd_out_data, exp_out.pop_front());
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Reset state
    @(negedge clk);
    check("R11 reset irq", {15'd0, host_irq}, 16'd0);
    check("R1 reset out valid", {15'd0, brd_out_valid}, 16'd0);
    @(posedge clk); #1;
    host_read(3'd2, v);
    check("R4 reset status", v, 16'h0021);

    // Wide mode traffic
    host_push(16'h1234); host_push(16'hABCD); host_push(16'h0F0F);
    check_status("R4 out partly filled");
    repeat (3) brd_pop();
    brd_push(16'hBEEF); brd_push(16'h1357);
    check_status("R4 in partly filled");
    host_pop("R1 inbound wide 1");
    host_pop("R2 inbound wide 2");

    // Narrow mode traffic
    wide_mode = 1'b0;
    host_push(16'h55AA);
    brd_pop();
    brd_push(16'h77EE);
    host_pop("R2 narrow inbound");
    wide_mode = 1'b1;

    // Capacity at strap 1 (8 entries)
    depth_strap = 2'd1;
    for (int i = 0; i < 9; i++) host_push(16'h0100 + 16'(i));
    check_status("R3 R5 outbound full and half");
    repeat (8) brd_pop();
    for (int i = 0; i < 9; i++) brd_push(16'hA000 + 16'(i));
    @(negedge clk);
    check("R3 in ready low when full", {15'd0, brd_in_ready}, 16'd0);
    @(posedge clk); #1;
    check_status("R3 R5 inbound full and half");
    for (int i = 0; i < 8; i++) host_pop("R3 inbound drain");
    host_pop("R12 empty read zero");
    check_status("R12 status unchanged");

    // Interrupt enables
    host_write(3'd2, 16'h0001);
    @(negedge clk); check("R6 out empty irq", {15'd0, host_irq}, 16'd1); @(posedge clk); #1;
    host_write(3'd2, 16'h0008);
    @(negedge clk); check("R6 in empty irq", {15'd0, host_irq}, 16'd1); @(posedge clk); #1;
    host_write(3'd2, 16'h0040);
    @(negedge clk); check("R6 in mail idle", {15'd0, host_irq}, 16'd0); @(posedge clk); #1;
    brd_mail_wdata = 8'hFF; brd_mail_wr = 1'b1; m_in_mail = 1;
    @(posedge clk); #1; brd_mail_wr = 1'b0;
    @(negedge clk); check("R6 in mail irq", {15'd0, host_irq}, 16'd1); @(posedge clk); #1;
    host_write(3'd2, 16'h0012);
    @(negedge clk); check("R6 reserved bits", {15'd0, host_irq}, 16'd0); @(posedge clk); #1;
    host_write(3'd2, 16'h0004);
    @(negedge clk); check("R6 out full idle", {15'd0, host_irq}, 16'd0); @(posedge clk); #1;

    // Inbound mailbox
    check_status("R10 in mail flag set");
    host_read(3'd3, v); m_in_mail = 0;
    check("R7 inbound mailbox trim", v, 16'h00FC);
    check_status("R10 in mail flag cleared");

    // Outbound mailbox
    host_write(3'd3, 16'h006B); m_out_pend = 1;
    @(negedge clk);
    check("R7 outbound trim", {8'h00, brd_out_mail}, 16'h0068);
    @(posedge clk); #1;
    check_status("R9 out mail pending");
    brd_mail_rd = 1'b1; @(posedge clk); #1; brd_mail_rd = 1'b0; m_out_pend = 0;
    check_status("R9 pending dropped");
    @(negedge clk);
    check("R9 contents kept", {8'h00, brd_out_mail}, 16'h0068);
    @(posedge clk); #1;
    host_write(3'd2, 16'h0080);
    host_read(3'd3, v);
    check("R8 readback outbound", v, 16'h0068);
    host_write(3'd2, 16'h0000);
    host_read(3'd3, v);
    check("R8 readback inbound", v, 16'h00FC);

    // Reset write
    host_push(16'h1111);
    host_write(3'd2, 16'h0001);
    host_write(3'd7, 16'h0000);
    exp_out.delete(); exp_in.delete(); m_out_pend = 0; m_in_mail = 0;
    @(negedge clk);
    check("R11 board reset pulse", {15'd0, brd_reset}, 16'd1);
    check("R11 irq cleared", {15'd0, host_irq}, 16'd0);
    check("R11 out fifo empty", {15'd0, brd_out_valid}, 16'd0);
    check("R11 out mailbox zero", {8'h00, brd_out_mail}, 16'h0000);
    @(posedge clk); #1;
    @(negedge clk);
    check("R11 pulse one cycle", {15'd0, brd_reset}, 16'd0);
    @(posedge clk); #1;
    check_status("R11 status after reset");
    host_read(3'd3, v);
    check("R11 mailbox cleared", v, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule